// File: doc/BRIEF.md
# Clock Frequency Monitor

This block measures one clock against a free-running reference clock and reports when that clock runs too slowly, too fast, or not at all. A counter in the monitored domain counts rising edges without stopping. Its value crosses into the reference domain as a Gray code through a two-flop synchronizer. A window counter in the reference domain samples the crossed count at the end of each window, which is a programmed number of reference cycles. It compares the difference from the previous sample with a lower and an upper bound.

Software sets the block up through a small register port. The registers hold the enable, the two bounds, the window length, the choice between an interrupt and a reset request, and a status word whose bits stay set until software writes a one to them. Each instance is set up on its own. When the parameter `LOW_ONLY` is set, the instance only checks that the clock is not too slow, and it always answers with an interrupt. This mode suits a monitor placed on an external crystal.

Top module: `clk_freq_monitor`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the status register (address 4) reads 0, the window register (address 3) reads `WIN_RST`, and `irq_o` and `rst_req_o` are low.
- R2: While the enable bit (control bit 0) is 0, no status bit becomes set, whatever the monitored clock does.
- R3: The low flag (status bit 0) is set when the number of monitored edges counted in one window is less than the lower bound (address 1).
- R4: The high flag (status bit 1) is set when the number of monitored edges counted in one window is greater than the upper bound (address 2).
- R5: The lost-clock flag (status bit 2) is set when a full window sees no monitored edge. This happens whatever the bounds are, including a lower bound of 0.
- R6: While enabled with the lower bound greater than the upper bound, the configuration-error flag (status bit 3) is set and the low and high flags are not set.
- R7: Status bits stay set until software writes a 1 to that bit position at address 4. Writing 0 leaves a bit unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: When control bit 1 is 0, `irq_o` is high while any status bit is set. When control bit 1 is 1, `rst_req_o` is high while any of status bits 0 to 2 is set, and `irq_o` follows only status bit 3.
- R9: With `LOW_ONLY` set, the high flag and the configuration-error flag are never set, `rst_req_o` stays low, and the low and lost-clock flags raise `irq_o`.
- R10: A window lasts the number of reference cycles held in the window register. Measuring begins at the rising edge of the enable bit, so the first window is a complete one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_mon | input | 1 | Clock under observation |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
A software write-one-to-clear of a status bit can land in the very cycle in which a window ends and sets that same bit again. The bench stops the monitored clock, so every window raises the lost-clock flag. It finds the cycle in which a window ends by clearing the flag and then polling until the flag comes back. It then times a clear of the flag to land exactly one window later. The flag must still read 1 after that write. A second clear, one cycle past a window end, must leave it reading 0.

// File: rtl/clk_freq_monitor.sv
module clk_freq_monitor #(
  parameter int       CNT_W    = 16,
  parameter int       WIN_W    = 16,
  parameter int       WIN_RST  = 256,
  parameter bit       LOW_ONLY = 1'b0
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        clk_mon,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        irq_o,
  output logic        rst_req_o
);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_LO   = 3'd1;
  localparam logic [2:0] A_HI   = 3'd2;
  localparam logic [2:0] A_WIN  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  // monitored domain: free-running edge counter, registered Gray copy
  logic [CNT_W-1:0] m_bin, m_gray;
  wire  [CNT_W-1:0] m_nxt = m_bin + 1'b1;

  always_ff @(posedge clk_mon or negedge rst_n)
    if (!rst_n) begin
      m_bin  <= '0;
      m_gray <= '0;
    end else begin
      m_bin  <= m_nxt;
      m_gray <= m_nxt ^ (m_nxt >> 1);
    end

  // reference domain
  logic [CNT_W-1:0] s1, s2, s_bin, prev;
  logic             en, en_q, resp;
  logic [CNT_W-1:0] lo, hi;
  logic [WIN_W-1:0] win, win_cnt;
  logic [3:0]       st;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= m_gray;
      s2 <= s1;
    end

  always_comb
    for (int i = 0; i < CNT_W; i++) s_bin[i] = ^(s2 >> i);

  wire [CNT_W-1:0] delta   = s_bin - prev;
  wire             start   = en & ~en_q;
  wire             win_end = en & ~start & (win_cnt == win - 1'b1);
  wire             cfg_bad = !LOW_ONLY && (lo > hi);

  wire set_low  = win_end && !cfg_bad && (delta < lo);
  wire set_high = win_end && !cfg_bad && !LOW_ONLY && (delta > hi);
  wire set_lost = win_end && (delta == '0);
  wire set_cfg  = en && cfg_bad;

  wire       wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire       wr_lo   = reg_we && reg_addr == A_LO;
  wire       wr_hi   = reg_we && reg_addr == A_HI;
  wire       wr_win  = reg_we && reg_addr == A_WIN;
  wire [3:0] clr     = (reg_we && reg_addr == A_STAT) ? reg_wdata[3:0] : 4'd0;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      en   <= 1'b0;
      resp <= 1'b0;
      lo   <= '0;
      hi   <= '1;
      win  <= WIN_W'(WIN_RST);
    end else begin
      if (wr_ctrl) begin
        en   <= reg_wdata[0];
        resp <= reg_wdata[1];
      end
      if (wr_lo)  lo  <= reg_wdata[CNT_W-1:0];
      if (wr_hi)  hi  <= reg_wdata[CNT_W-1:0];
      if (wr_win) win <= reg_wdata[WIN_W-1:0];
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      en_q    <= 1'b0;
      win_cnt <= '0;
      prev    <= '0;
    end else begin
      en_q <= en;
      if (start || win_end) begin
        win_cnt <= '0;
        prev    <= s_bin;
      end else if (en) begin
        win_cnt <= win_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) st <= 4'd0;
    else        st <= (st & ~clr) | {set_cfg, set_lost, set_high, set_low};

  wire fault = |st[2:0];
  assign irq_o     = (fault && (!resp || LOW_ONLY)) || st[3];
  assign rst_req_o = fault && resp && !LOW_ONLY;

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_CTRL:  reg_rdata[1:0]       = {resp, en};
      A_LO:    reg_rdata[CNT_W-1:0] = lo;
      A_HI:    reg_rdata[CNT_W-1:0] = hi;
      A_WIN:   reg_rdata[WIN_W-1:0] = win;
      A_STAT:  reg_rdata[3:0]       = st;
      default: reg_rdata            = '0;
    endcase
  end

  // R2
  idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !en |=> !($rose(st[0]) || $rose(st[1]) || $rose(st[2]) || $rose(st[3])));

  // R5
  lost_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(st[2]) |-> $past(win_end));

  // R6
  cfg_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(st[3]) |-> $past(en && (lo > hi)));

  // R7
  sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(st[2]) |-> $past(reg_we && reg_addr == A_STAT && reg_wdata[2]));

endmodule

// File: tb/sim_clk_freq_monitor.sv
`timescale 1ns/1ps
module sim_clk_freq_monitor;
  logic clk = 1'b0, mclk = 1'b0, rst_n = 1'b0;
  int   mon_hp = 5;
  int   n_run = 0, n_fail = 0;

  logic        we0 = 0, we1 = 0;
  logic [2:0]  addr = 0, raddr = 0;
  logic [31:0] wdata = 0, rdata0, rdata1;
  logic        irq0, rst0, irq1, rst1;

  always #10 clk = ~clk;
  always begin
    if (mon_hp == 0) wait (mon_hp != 0);
    else #(mon_hp) mclk = ~mclk;
  end

  clk_freq_monitor u0 (.clk_ref(clk), .rst_n(rst_n), .clk_mon(mclk),
    .reg_we(we0), .reg_addr(addr), .reg_wdata(wdata), .reg_raddr(raddr),
    .reg_rdata(rdata0), .irq_o(irq0), .rst_req_o(rst0));

  clk_freq_monitor #(.LOW_ONLY(1'b1)) u1 (.clk_ref(clk), .rst_n(rst_n), .clk_mon(mclk),
    .reg_we(we1), .reg_addr(addr), .reg_wdata(wdata), .reg_raddr(raddr),
    .reg_rdata(rdata1), .irq_o(irq1), .rst_req_o(rst1));

  // hp, lo, hi, win, exp_low, exp_high, exp_lost
  localparam int VEC [8][7] = '{
    '{5, 150, 250, 100, 0, 0, 0},
    '{10, 150, 250, 100, 1, 0, 0},
    '{2, 150, 250, 100, 0, 1, 0},
    '{5, 210, 250, 100, 1, 0, 0},
    '{5, 150, 190, 100, 0, 1, 0},
    '{0, 150, 250, 100, 1, 0, 1},
    '{0, 0, 250, 100, 0, 0, 1},
    '{5, 150, 250, 50, 1, 0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit which, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (which) we1 = 1; else we0 = 1;
    @(negedge clk);
    we0 = 0; we1 = 0;
  endtask

  task automatic rd(input bit which, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    raddr = a;
    #1 d = which ? rdata1 : rdata0;
  endtask

  task automatic setup(input bit which, input int hp, input int lo, input int hi,
                       input int w, input int ctrl);
    wr(which, 3'd0, 0);
    mon_hp = hp;
    wr(which, 3'd1, lo);
    wr(which, 3'd2, hi);
    wr(which, 3'd3, w);
    wr(which, 3'd4, 32'hF);
    wr(which, 3'd0, ctrl);
    repeat (3 * w + 20) @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(0, 3'd0, d); chk("R1 ctrl", d, 0);
    rd(0, 3'd4, d); chk("R1 status", d, 0);
    rd(0, 3'd3, d); chk("R1 window", d, 256);
    chk("R1 irq", irq0, 0);
    chk("R1 rst_req", rst0, 0);

    // R2: disabled, stopped clock, tight bounds
    mon_hp = 0;
    wr(0, 3'd1, 150);
    wr(0, 3'd3, 50);
    repeat (200) @(posedge clk);
    rd(0, 3'd4, d); chk("R2 idle status", d, 0);

    // R3 R4 R5 R10: vector table
    for (int i = 0; i < 8; i++) begin
      setup(0, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1);
      rd(0, 3'd4, d);
      chk($sformatf("R3 low v%0d", i), d[0], VEC[i][4]);
      chk($sformatf("R4 high v%0d", i), d[1], VEC[i][5]);
      chk($sformatf("R5 lost v%0d", i), d[2], VEC[i][6]);
      chk($sformatf("R10 cfg v%0d", i), d[3], 0);
      chk($sformatf("R8 irq v%0d", i), irq0, (VEC[i][4] | VEC[i][5] | VEC[i][6]));
    end

    // R7: sticky after clock recovers, write 0 keeps, write 1 clears
    setup(0, 10, 150, 250, 100, 1);
    mon_hp = 5;
    repeat (250) @(posedge clk);
    rd(0, 3'd4, d); chk("R7 sticky", d[0], 1);
    wr(0, 3'd4, 0);
    rd(0, 3'd4, d); chk("R7 write zero", d[0], 1);
    wr(0, 3'd4, 1);
    rd(0, 3'd4, d); chk("R7 w1c", d[0], 0);
    chk("R7 irq drop", irq0, 0);

    // R8: reset response
    setup(0, 10, 150, 250, 100, 3);
    chk("R8 rst_req", rst0, 1);
    chk("R8 no irq", irq0, 0);

    // R6: bounds inverted
    setup(0, 5, 300, 100, 100, 3);
    rd(0, 3'd4, d);
    chk("R6 cfg flag", d[3], 1);
    chk("R6 low suppressed", d[0], 0);
    chk("R6 high suppressed", d[1], 0);
    chk("R6 irq", irq0, 1);
    chk("R6 no rst_req", rst0, 0);

    // R7: clear colliding with a window-end set
    setup(0, 0, 0, 250, 100, 1);
    do begin
      wr(0, 3'd4, 4);
      rd(0, 3'd4, d);
    end while (d[2]);
    do rd(0, 3'd4, d); while (!d[2]);
    repeat (99) @(posedge clk);
    @(negedge clk); addr = 3'd4; wdata = 4; we0 = 1;
    @(posedge clk);
    @(negedge clk); we0 = 0; raddr = 3'd4;
    #1 chk("R7 set wins collision", rdata0[2], 1);
    wr(0, 3'd4, 4);
    rd(0, 3'd4, d); chk("R7 clear off boundary", d[2], 0);

    // R9: low-only instance
    setup(1, 2, 150, 250, 100, 3);
    rd(1, 3'd4, d); chk("R9 high ignored", d, 0);
    setup(1, 5, 300, 100, 100, 3);
    rd(1, 3'd4, d);
    chk("R9 low flag", d[0], 1);
    chk("R9 no cfg", d[3], 0);
    chk("R9 irq", irq1, 1);
    chk("R9 no rst_req", rst1, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule